// File: doc/BRIEF.md
# TLB Victim Slot Index Generator

This block supplies the slot number that a translation buffer uses when software asks for an entry to be replaced at a location the hardware picks. It holds two small registers. One is a down-counter that moves by one slot each time an instruction retires. The other is a software-set floor that protects the lowest slots from replacement.

When the counter has reached the floor or gone below it, the next retired instruction reloads it to the top slot, 31, and does not decrement it. The replacement index therefore cycles through the unprotected slots and never selects a protected one.

Both registers sit in a 32-bit register window. Only the low six bits hold state, and the upper bits always read as zero. Software can write only the floor. A write aimed at the counter has no effect. Writing the floor also restarts the counter at the top slot.

Top module: `victim_index_gen`

## Requirements
- R1: While `rst` is high, the counter is set to 31 and the floor to 0, and both read ports show these values after the clock edge.
- R2: Bits 31:6 of `rd_random` and `rd_wired` always read as zero.
- R3: On a clock edge with `retire` high, no floor write, and counter greater than floor, the counter decreases by exactly one.
- R4: On a clock edge with `retire` high, no floor write, and counter less than or equal to floor, the counter reloads to 31 and is not decremented.
- R5: On a clock edge with `retire` low and no floor write, the counter keeps its value.
- R6: A write with `wr_sel` = 0 (the counter's address) changes neither register. With `retire` low, both read ports keep their values.
- R7: A write with `wr_sel` = 1 stores `wr_data[5:0]` into the floor and sets the counter to 31 on the same edge. This takes priority over a decrement from a simultaneous `retire`.
- R8: After reset, the counter always lies between the floor and 31 inclusive. When the floor holds a value above 31, the counter stays at 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire | input | 1 | One pulse per retired instruction |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = counter (ignored), 1 = floor |
| wr_data | input | 32 | Write data |
| rd_random | output | 32 | Counter value, zero-extended |
| rd_wired | output | 32 | Floor value, zero-extended |

## Verification
The hardest case to reach is a reload that coincides with another event. One example is `retire` arriving while the counter already equals the floor. Another is a floor write in the same cycle as a retire. A third is a floor above 31, which leaves the counter below the floor from the moment of the write.

The stimulus first lets full countdowns run with several floor values, including 0, 30 and 31, so that the counter actually lands on the floor. It then issues writes and retires together on chosen cycles. Finally it loads a floor above 31 and follows with random mixes of retires and writes to either address.

// File: rtl/victim_pkg.sv
package victim_pkg;

  typedef enum logic {
    SEL_COUNTER = 1'b0,
    SEL_FLOOR   = 1'b1
  } reg_sel_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_WRAP = 2'd2,
    ACT_LOAD = 2'd3
  } cnt_act_e;

endpackage

// File: rtl/victim_floor_reg.sv
module victim_floor_reg #(
  parameter int IDX_W = 6,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [REG_W-1:0] din,
  output logic [IDX_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din[IDX_W-1:0];
  end

endmodule

// File: rtl/victim_step_ctrl.sv
module victim_step_ctrl
  import victim_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             retire,
  input  logic             floor_load,
  input  logic [IDX_W-1:0] cur,
  input  logic [IDX_W-1:0] floor_v,
  output cnt_act_e         act
);

  logic at_or_below;

  assign at_or_below = (cur <= floor_v);

  always_comb begin
    if (floor_load)       act = ACT_LOAD;
    else if (!retire)     act = ACT_HOLD;
    else if (at_or_below) act = ACT_WRAP;
    else                  act = ACT_STEP;
  end

endmodule

// File: rtl/victim_counter.sv
module victim_counter
  import victim_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int TOP_IDX = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_act_e         act,
  output logic [IDX_W-1:0] q
);

  localparam logic [IDX_W-1:0] TOP_V = IDX_W'(TOP_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= TOP_V;
    end else begin
      unique case (act)
        ACT_STEP: q <= q - 1'b1;
        ACT_WRAP,
        ACT_LOAD: q <= TOP_V;
        default:  q <= q;
      endcase
    end
  end

endmodule

// File: rtl/victim_readout.sv
module victim_readout #(
  parameter int IDX_W = 6,
  parameter int REG_W = 32
) (
  input  logic [IDX_W-1:0] val,
  output logic [REG_W-1:0] word
);

  localparam int PAD_W = REG_W - IDX_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign word = {{PAD_W{1'b0}}, val};
    end else begin : g_nopad
      assign word = val[REG_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/victim_index_gen.sv
module victim_index_gen
  import victim_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int REG_W   = 32,
  parameter int TOP_IDX = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             retire,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_random,
  output logic [REG_W-1:0] rd_wired
);

  logic             floor_load;
  logic [IDX_W-1:0] floor_q;
  logic [IDX_W-1:0] cnt_q;
  cnt_act_e         act;

  assign floor_load = wr_en && (reg_sel_e'(wr_sel) == SEL_FLOOR);

  victim_floor_reg #(.IDX_W(IDX_W), .REG_W(REG_W)) u_floor (
    .clk  (clk),
    .rst  (rst),
    .load (floor_load),
    .din  (wr_data),
    .q    (floor_q)
  );

  victim_step_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .retire     (retire),
    .floor_load (floor_load),
    .cur        (cnt_q),
    .floor_v    (floor_q),
    .act        (act)
  );

  victim_counter #(.IDX_W(IDX_W), .TOP_IDX(TOP_IDX)) u_cnt (
    .clk (clk),
    .rst (rst),
    .act (act),
    .q   (cnt_q)
  );

  victim_readout #(.IDX_W(IDX_W), .REG_W(REG_W)) u_rd_cnt (
    .val  (cnt_q),
    .word (rd_random)
  );

  victim_readout #(.IDX_W(IDX_W), .REG_W(REG_W)) u_rd_floor (
    .val  (floor_q),
    .word (rd_wired)
  );

endmodule

// File: rtl/victim_index_gen_chk.sv
module victim_index_gen_chk #(
  parameter int IDX_W   = 6,
  parameter int REG_W   = 32,
  parameter int TOP_IDX = 31
) (
  input logic             clk,
  input logic             rst,
  input logic             retire,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_random,
  input logic [REG_W-1:0] rd_wired
);

  localparam logic [REG_W-1:0] TOP_W  = REG_W'(TOP_IDX);
  localparam logic [REG_W-1:0] HI_MSK = ~((REG_W'(1) << IDX_W) - REG_W'(1));

  logic wr_floor;
  assign wr_floor = wr_en && wr_sel;

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (rd_random == TOP_W) && (rd_wired == '0));

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    ((rd_random & HI_MSK) == '0) && ((rd_wired & HI_MSK) == '0));

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    (retire && !wr_floor && (rd_random > rd_wired))
      |=> (rd_random == $past(rd_random) - 1));

  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (retire && !wr_floor && (rd_random <= rd_wired)) |=> (rd_random == TOP_W));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!retire && !wr_floor) |=> $stable(rd_random));

  p_ignore_r6: assert property (@(posedge clk) disable iff (rst)
    (!wr_floor) |=> $stable(rd_wired));

  p_floor_wr_r7: assert property (@(posedge clk) disable iff (rst)
    wr_floor |=> (rd_wired == ($past(wr_data) & ~HI_MSK)) && (rd_random == TOP_W));

  p_range_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_wired <= TOP_W) ? ((rd_random >= rd_wired) && (rd_random <= TOP_W))
                        : (rd_random == TOP_W));

endmodule

bind victim_index_gen victim_index_gen_chk #(
  .IDX_W(IDX_W), .REG_W(REG_W), .TOP_IDX(TOP_IDX)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .retire    (retire),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .rd_random (rd_random),
  .rd_wired  (rd_wired)
);

// File: tb/sim_victim_index_gen.sv
module sim_victim_index_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        retire = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_random;
  logic [31:0] rd_wired;

  int    total = 0;
  int    bad = 0;
  int    m_rand = 31;
  int    m_floor = 0;
  string m_tag = "R1";

  always #4 clk = ~clk;

  victim_index_gen u0 (
    .clk       (clk),
    .rst       (rst),
    .retire    (retire),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .rd_random (rd_random),
    .rd_wired  (rd_wired)
  );

  // Behavioural reference model, advanced on each rising edge.
  always @(posedge clk) begin
    if (rst) begin
      m_rand = 31; m_floor = 0; m_tag = "R1";
    end else if (wr_en && wr_sel) begin
      m_floor = int'(wr_data % 64); m_rand = 31; m_tag = "R7";
    end else if (retire) begin
      if (m_rand <= m_floor) begin m_rand = 31; m_tag = "R4"; end
      else begin m_rand = m_rand - 1; m_tag = "R3"; end
    end else begin
      m_tag = wr_en ? "R6" : "R5";
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk(m_tag, rd_random, 32'(m_rand));
    chk(m_tag, rd_wired, 32'(m_floor));
    chk("R2", {rd_random[31:6], rd_wired[31:6]}, '0);
    if (m_floor <= 31)
      chk("R8", 32'((rd_random >= rd_wired) && (rd_random <= 31)), 32'd1);
    else
      chk("R8", rd_random, 32'd31);
  endtask

  task automatic cyc(input logic r, input logic e, input logic s, input logic [31:0] d);
    @(negedge clk);
    if (!rst) compare();
    retire = r; wr_en = e; wr_sel = s; wr_data = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", rd_random, 32'd31);
    chk("R1", rd_wired, 32'd0);
    rst = 1'b0;
    // R3/R4: full countdown with floor 0
    for (int i = 0; i < 70; i++) cyc(1'b1, 1'b0, 1'b0, '0);
    // R5: idle cycles hold
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 1'b0, '0);
    // R6: counter-address write ignored, with and without retire
    cyc(1'b0, 1'b1, 1'b0, 32'h0000_0003);
    cyc(1'b0, 1'b0, 1'b0, '0);
    cyc(1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF);
    cyc(1'b0, 1'b0, 1'b0, '0);
    // R7: floor write with simultaneous retire
    cyc(1'b1, 1'b1, 1'b1, 32'hABCD_0005);
    for (int i = 0; i < 60; i++) cyc(1'b1, 1'b0, 1'b0, '0);
    // R4 edge: floor 30 and 31
    cyc(1'b0, 1'b1, 1'b1, 32'd30);
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, 1'b0, '0);
    cyc(1'b1, 1'b1, 1'b1, 32'd31);
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, 1'b0, '0);
    // R8: floor above 31 keeps counter at 31
    cyc(1'b0, 1'b1, 1'b1, 32'hFFFF_FFE3);
    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, 1'b0, '0);
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic e;
      logic [31:0] d;
      e = ($urandom % 16) == 0;
      d = (($urandom % 4) == 0) ? $urandom : ($urandom % 32);
      cyc(1'($urandom % 4 != 0), e, 1'($urandom), d);
    end
    cyc(1'b0, 1'b0, 1'b0, '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule